// File: doc/BRIEF.md
# Multi-Pipe Buffer Access Port with Rewind

This block is a shared access port that a processor uses to read and write a set of per-pipe packet buffers. The processor first writes a select register. This write names the pipe to serve, sets the access width, and carries a rewind flag. After that, the processor reads or writes a single data register. Each data access moves one, two or four bytes between the bus and the selected pipe's buffer.

The port keeps a separate byte pointer for every pipe. Software can therefore suspend a transfer on one pipe, serve another pipe, and return to the first. When it returns, it chooses through the rewind flag whether the first pipe picks up where it stopped or starts again at byte zero. A ready flag drops on every selection and rises after a fixed lookup latency. A data access made while ready is low does nothing except set a sticky error flag. The buffer storage is inside the block as four byte-lane RAMs, so accesses at any byte alignment need only one RAM port per lane.

The bus has three registers. Address 0 is select and status, address 1 is data, and address 2 clears the error flag. Read data appears on `bus_rdata` in the cycle after the read strobe.

Top module: `pipe_port_top`

## Requirements
- R1: A write to address 0 with bit 7 (rewind) at 1 and a valid pipe in bits 3:0 sets that pipe's pointer to byte 0.
- R2: A write to address 0 with bit 7 at 0 leaves the chosen pipe's pointer unchanged, so access resumes at its saved position.
- R3: Every pipe has its own pointer. Accesses to one pipe never move another pipe's pointer, so a switch away and back loses no position.
- R4: The rewind flag acts only in a write to address 0. Bit 7 set in a write to any other address rewinds no pointer.
- R5: A write to address 0 forces ready (port_ready) low in the following cycle. Ready stays low until the lookup latency has elapsed.
- R6: Ready is observed high from the second rising edge after the select write, provided the pipe value is below PIPES (0 to 9 by default). Value 15, and any other value of PIPES or above, keeps ready low.
- R7: Bits 9:8 of the select write set the access width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Each accepted data access advances the selected pointer by that width.
- R8: A data access made while ready is 0 changes no buffer byte and no pointer, returns 0 on a read, and sets the error flag (port_err). The flag stays set until a write to address 2.
- R9: A data read returns the byte at the pointer in bits 7:0 and the following bytes in bits 15:8, 23:16 and 31:24, up to the access width. Lanes beyond the width read as 0. The data appears in the cycle after the read strobe.
- R10: A data write stores bus bits 7:0 at the pointer and the next lanes at the following bytes, up to the width. Byte addresses wrap modulo the buffer size (64 bytes by default).
- R11: A read of address 0 returns the pipe in bits 3:0, the width code in bits 9:8, ready in bit 16 and the error flag in bit 17. All other bits are 0.
- R12: Pipe 0 is a valid selection and behaves like every other pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address: 0 select/status, 1 data, 2 error clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| port_ready | output | 1 | Selected buffer may be accessed |
| port_err | output | 1 | Sticky flag for an access made while not ready |

## Verification
The bench reads from a pipe, suspends the transfer, works on other pipes, and then returns both with and without rewind. A design that shared one pointer across pipes, or that cleared pointers on every selection, would return the wrong bytes at that point. The bench times the ready flag edge by edge after each select write, and it makes accesses on the very next cycle after a select. A design with the wrong latency, or one that accepted an early access, would show a moved pointer or a missing error flag. Directed cases cover: bit 7 set in writes to the non-select addresses, pipe 0, select value 15, pointer wrap across the buffer end with four-byte accesses, and mixed access widths at unaligned pointers. Any lane mapping error shows up as shuffled or non-zero bytes.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    A_SEL    = 2'd0,
    A_DATA   = 2'd1,
    A_ERRCLR = 2'd2,
    A_RSVD   = 2'd3
  } addr_e;

  typedef enum logic [1:0] {
    RD_STAT = 2'd0,
    RD_DATA = 2'd1,
    RD_ZERO = 2'd2
  } rd_mode_e;

  // Access width in bytes for a width code
  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pport_lane_ram.sv
module pport_lane_ram #(
  parameter int DEPTH = 160,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl #(
  parameter int PIPES     = 10,
  parameter int PW        = 6,
  parameter int SELW      = 4,
  parameter int READY_LAT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel_wr,
  input  logic [SELW-1:0] sel_pipe,
  input  logic            sel_rew,
  input  logic [1:0]      sel_wcode,
  input  logic            err_clr,
  input  logic            acc,
  output logic [SELW-1:0] cur_pipe,
  output logic [PW-1:0]   cur_ptr,
  output logic [1:0]      wcode,
  output logic [2:0]      width,
  output logic            ready,
  output logic            err
);
  import pport_pkg::*;
  localparam int CW = $clog2(READY_LAT + 1);
  localparam logic [SELW-1:0] NONE = '1;

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] ptr_q [PIPES];
  logic          acc_ok;
  logic          new_valid;
  logic          cur_valid;

  assign new_valid = (int'(sel_pipe) < PIPES);
  assign cur_valid = (int'(cur_pipe) < PIPES);
  assign acc_ok    = acc && ready;
  assign width     = width_bytes(wcode);

  always_comb begin
    cur_ptr = '0;
    for (int i = 0; i < PIPES; i++)
      if (cur_pipe == SELW'(i)) cur_ptr = ptr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_pipe <= NONE;
      wcode    <= 2'd0;
      cnt_q    <= '0;
      ready    <= 1'b0;
      err      <= 1'b0;
      for (int i = 0; i < PIPES; i++) ptr_q[i] <= '0;
    end else begin
      if (sel_wr) begin
        cur_pipe <= sel_pipe;
        wcode    <= sel_wcode;
        cnt_q    <= CW'(READY_LAT);
        ready    <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) ready <= cur_valid;
      end
      for (int i = 0; i < PIPES; i++) begin
        if (sel_wr && sel_rew && sel_pipe == SELW'(i))
          ptr_q[i] <= '0;
        else if (acc_ok && !sel_wr && cur_pipe == SELW'(i))
          ptr_q[i] <= ptr_q[i] + PW'(width);
      end
      if (err_clr)          err <= 1'b0;
      else if (acc && !ready) err <= 1'b1;
    end
  end

  // R1
  rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr && sel_rew && new_valid |=> cur_ptr == '0);
  // R2
  resume_keep_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr && !sel_rew && new_valid |=> cur_ptr == $past(ptr_q[sel_pipe]));
  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> !ready);
  // R6
  ready_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> cur_valid);
  // R7
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    acc && ready && !sel_wr |=> cur_ptr == $past(cur_ptr) + PW'($past(width)));
  // R8
  ignored_acc_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !ready && !sel_wr && !err_clr |=> err && cur_ptr == $past(cur_ptr));
endmodule

// File: rtl/pipe_port_top.sv
module pipe_port_top #(
  parameter int PIPES     = 10,
  parameter int BUF_BYTES = 64,
  parameter int READY_LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        port_ready,
  output logic        port_err
);
  import pport_pkg::*;
  localparam int SELW      = 4;
  localparam int PW        = $clog2(BUF_BYTES);
  localparam int ROWS      = BUF_BYTES / LANES;
  localparam int RAM_DEPTH = PIPES * ROWS;
  localparam int RAW       = $clog2(RAM_DEPTH);

  logic            sel_wr, err_clr, acc, wr_ok;
  logic [SELW-1:0] cur_pipe, pidx;
  logic [PW-1:0]   cur_ptr;
  logic [1:0]      wcode;
  logic [2:0]      width;
  logic [7:0]      lane_q [LANES];

  rd_mode_e        rd_mode_q;
  logic [1:0]      rd_off_q;
  logic [2:0]      rd_w_q;
  logic [31:0]     stat_q;

  assign sel_wr  = bus_wr && bus_addr == A_SEL;
  assign err_clr = bus_wr && bus_addr == A_ERRCLR;
  assign acc     = (bus_wr || bus_rd) && bus_addr == A_DATA;
  assign wr_ok   = bus_wr && bus_addr == A_DATA && port_ready;
  assign pidx    = (int'(cur_pipe) < PIPES) ? cur_pipe : '0;

  pport_ctrl #(
    .PIPES(PIPES), .PW(PW), .SELW(SELW), .READY_LAT(READY_LAT)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .sel_wr   (sel_wr),
    .sel_pipe (bus_wdata[3:0]),
    .sel_rew  (bus_wdata[7]),
    .sel_wcode(bus_wdata[9:8]),
    .err_clr  (err_clr),
    .acc      (acc),
    .cur_pipe (cur_pipe),
    .cur_ptr  (cur_ptr),
    .wcode    (wcode),
    .width    (width),
    .ready    (port_ready),
    .err      (port_err)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [1:0]     off;
    logic [PW-1:0]  baddr;
    logic [RAW-1:0] row;
    logic           we;
    logic [7:0]     wbyte;

    assign off   = 2'(b) - cur_ptr[1:0];
    assign baddr = cur_ptr + PW'(off);
    assign row   = RAW'(pidx) * RAW'(ROWS) + RAW'(baddr >> 2);
    assign we    = wr_ok && ({1'b0, off} < width);
    assign wbyte = bus_wdata[8*off +: 8];

    pport_lane_ram #(.DEPTH(RAM_DEPTH), .AW(RAW)) u_ram (
      .clk  (clk),
      .we   (we),
      .addr (row),
      .wdata(wbyte),
      .rdata(lane_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_mode_q <= RD_ZERO;
      rd_off_q  <= '0;
      rd_w_q    <= '0;
      stat_q    <= '0;
    end else if (bus_rd) begin
      rd_off_q <= cur_ptr[1:0];
      rd_w_q   <= width;
      stat_q   <= {14'd0, port_err, port_ready, 6'd0, wcode, 4'd0, cur_pipe};
      if (bus_addr == A_SEL)                    rd_mode_q <= RD_STAT;
      else if (bus_addr == A_DATA && port_ready) rd_mode_q <= RD_DATA;
      else                                       rd_mode_q <= RD_ZERO;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (rd_mode_q)
      RD_STAT: bus_rdata = stat_q;
      RD_DATA:
        for (int k = 0; k < LANES; k++)
          if (k < int'(rd_w_q)) bus_rdata[8*k +: 8] = lane_q[rd_off_q + 2'(k)];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/test_pipe_port_top.sv
module test_pipe_port_top;
  localparam int PIPES = 10;
  localparam int BUF   = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        port_ready, port_err;

  int errors = 0, checks = 0;
  logic [7:0] mem_m [PIPES][BUF];
  int ptr_m [PIPES];
  int sel_m = 15, wc_m = 0;
  bit ready_m = 0, err_m = 0, done = 0;

  pipe_port_top i_pipe_port_top (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wbytes(input int wc);
    return (wc == 0) ? 1 : (wc == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read();
    logic [31:0] v = '0;
    for (int k = 0; k < wbytes(wc_m); k++)
      v[8*k +: 8] = mem_m[sel_m][(ptr_m[sel_m] + k) % BUF];
    return v;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic select(input int p, input bit rew, input int wc, input bit wait_rdy);
    bus_write(2'd0, 32'(p) | (32'(rew) << 7) | (32'(wc) << 8));
    sel_m = p; wc_m = wc; ready_m = 0;
    if (rew && p < PIPES) ptr_m[p] = 0;
    check(port_ready == 0, "R5 ready low after select", 32'(port_ready), 0);
    if (wait_rdy) begin
      @(negedge clk);
      check(port_ready == 0, "R5 ready still low", 32'(port_ready), 0);
      @(negedge clk);
      ready_m = (p < PIPES);
      check(port_ready == ready_m, "R6 ready after latency", 32'(port_ready), 32'(ready_m));
    end
  endtask

  task automatic data_write(input logic [31:0] d);
    bus_write(2'd1, d);
    if (ready_m) begin
      for (int k = 0; k < wbytes(wc_m); k++)
        mem_m[sel_m][(ptr_m[sel_m] + k) % BUF] = d[8*k +: 8];
      ptr_m[sel_m] = (ptr_m[sel_m] + wbytes(wc_m)) % BUF;
    end else err_m = 1;
    check(port_err == err_m, "R8 error flag after write", 32'(port_err), 32'(err_m));
  endtask

  task automatic data_read(input string tag);
    logic [31:0] exp, d;
    exp = ready_m ? exp_read() : 32'd0;
    bus_read(2'd1, d);
    if (ready_m) ptr_m[sel_m] = (ptr_m[sel_m] + wbytes(wc_m)) % BUF;
    else err_m = 1;
    check(d == exp, tag, d, exp);
  endtask

  task automatic status_check(input string tag);
    logic [31:0] d, exp;
    exp = 32'(sel_m) | (32'(wc_m) << 8) | (32'(ready_m) << 16) | (32'(err_m) << 17);
    bus_read(2'd0, d);
    check(d == exp, tag, d, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int p = 0; p < PIPES; p++) ptr_m[p] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check(port_ready == 0 && port_err == 0, "R6 reset ready/err low", {port_ready, port_err}, 0);
    status_check("R11 reset status");

    // Fill every buffer (R10, R12 pipe 0 included)
    for (int p = 0; p < PIPES; p++) begin
      select(p, 1, 2, 1);
      for (int i = 0; i < BUF / 4; i++) data_write($urandom);
    end

    // R1 rewind then read from byte 0; R9 layout
    select(4, 1, 2, 1);
    data_read("R1 rewind read at byte 0");
    data_read("R9 second word");
    // R3 switch away and back; R2 resume
    select(7, 1, 0, 1);
    data_read("R3 other pipe byte");
    select(4, 0, 2, 1);
    data_read("R2 resume after switch");
    // R4 rewind bit in non-select writes
    bus_write(2'd2, 32'h80);
    bus_write(2'd3, 32'h80);
    data_read("R4 no rewind from other address");
    // R7 widths at unaligned pointer, R9 zero lanes
    select(4, 0, 0, 1);
    data_read("R7 one byte");
    select(4, 0, 1, 1);
    data_read("R9 two bytes unaligned");
    select(4, 0, 3, 1);
    data_read("R7 code 3 as four bytes");
    status_check("R11 status after reads");
    // R12 pipe 0
    select(0, 1, 2, 1);
    data_read("R12 pipe 0 read");
    // R6 none selection
    select(15, 0, 2, 1);
    status_check("R6 none keeps ready low");
    data_read("R8 read with none selected");
    check(port_err == 1, "R8 error sticky", 32'(port_err), 1);
    bus_write(2'd2, 0); err_m = 0;
    check(port_err == 0, "R8 error cleared", 32'(port_err), 0);
    // R8 access right after select is ignored
    select(5, 1, 2, 0);
    data_write(32'hDEADBEEF);
    @(negedge clk); ready_m = 1;
    data_read("R8 early write ignored");
    bus_write(2'd2, 0); err_m = 0;
    // R10 wrap
    select(3, 1, 1, 1);
    data_read("R10 wrap setup");
    select(3, 0, 2, 1);
    for (int i = 0; i < 15; i++) data_read("R10 walk");
    data_write(32'hA1B2C3D4);
    select(3, 0, 2, 1);
    for (int i = 0; i < 15; i++) data_read("R10 walk");
    data_read("R10 wrap across end");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) select($urandom_range(0, PIPES - 1), 1'($urandom_range(0, 1)), $urandom_range(0, 3), 1);
      else if (op < 5) data_write($urandom);
      else if (op < 9) data_read("R3 random read");
      else status_check("R11 random status");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule